// File: doc/BRIEF.md
# Controller Interrupt Flag Unit

This block gathers eight event sources of a bus controller into a flag register, masks them with an enable register, and drives a single interrupt line to the host. The protocol engine delivers each event as a one-cycle pulse on its own bit of `evtPulse`. The host reads and writes the two registers through a small register port with an address, a write strobe, write data and read data.

A pulse sets its flag whether or not that source is enabled. The host clears flags by writing ones to the flag register. While any flag is set whose enable bit is also set, the interrupt line stays high. Because the bus-error source has its own enable bit, the host can leave bus-error reporting off and still see bus errors recorded in the flag register.

The bit positions are the same in both registers and in `evtPulse`: bit 7 is bus error, bit 6 arbitration lost, bit 5 error passive, bit 4 wakeup, bit 3 data overrun, bit 2 error warning, bit 1 transmit done and bit 0 receive valid.

Top module: `evtirq_top`

## Requirements
- R1: While reset is held and after it is released, the flag register, the enable register and `irqOut` are all zero.
- R2: After the clock edge at which `evtPulse[i]` is high, flag bit i reads one whatever the value of enable bit i, in the bit order given above.
- R3: A read at word address 0 returns the flags in bits 7:0. A read at word address 1 returns the enables in bits 7:0. Bits 31:8 always read zero, and any other address reads zero.
- R4: A write to address 0 clears exactly those flag bits whose write-data bit is one and leaves the other flags unchanged. Write-data bits 31:8 are ignored.
- R5: When an event pulse and a clearing write for the same flag fall in the same cycle, the flag is set after that edge.
- R6: A write to address 1 loads write-data bits 7:0 into the enable register.
- R7: After every clock edge, `irqOut` equals the OR over all bits of flag AND enable, taken from the register values updated at that same edge.
- R8: A write of zero to the enable register drives `irqOut` low at the edge of that write, even with flags set or an event pulse in the same cycle.
- R9: With enable bits 6:0 set and bit 7 clear, a bus-error pulse sets flag bit 7 and leaves `irqOut` low. Setting enable bit 7 afterwards raises `irqOut`.
- R10: A write to any address other than 0 or 1 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register word address |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| evtPulse | input | 8 | One-cycle event pulses from the protocol engine |
| irqOut | output | 1 | Registered interrupt request |

## Verification
Two pairs of functions can act in the same cycle. An event pulse can coincide with a clearing write to the same flag bit. An enable write can coincide with an event pulse that would otherwise raise the interrupt. The bench provokes both with directed cases, and random traffic repeats them often because it mixes sparse pulses with writes to both registers. After each edge, the read-back flags and `irqOut` are judged against a bench model that applies the rule that a set beats a clear, and that computes the interrupt from the updated register values.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;
  // Register-access strobes passed from the decoder to the register datapath.
  typedef struct packed {
    logic flagClr;  // write to the flag register: clear the bits written as one
    logic enWr;     // write to the enable register
    logic rdFlag;   // the current address selects the flag register
    logic rdEn;     // the current address selects the enable register
  } strobe_t;
endpackage

// File: rtl/evtirq_ctrl.sv
module evtirq_ctrl
  import evtirq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 0,
  parameter int EN_ADDR   = 1
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output strobe_t           st
);
  logic hitFlag;
  logic hitEn;

  assign hitFlag = (regAddr == ADDR_W'(FLAG_ADDR));
  assign hitEn   = (regAddr == ADDR_W'(EN_ADDR));

  always_comb begin
    st         = '0;
    st.rdFlag  = hitFlag;
    st.rdEn    = hitEn;
    st.flagClr = regWrEn && hitFlag;
    st.enWr    = regWrEn && hitEn;
  end
endmodule

// File: rtl/evtirq_datapath.sv
module evtirq_datapath
  import evtirq_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_EVT-1:0] flagQ,
  output logic [NUM_EVT-1:0] enQ,
  output logic               irqOut
);
  localparam int PAD_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] flagNext;
  logic [NUM_EVT-1:0] enNext;
  logic [NUM_EVT-1:0] clrMask;

  assign clrMask = st.flagClr ? wrData[NUM_EVT-1:0] : '0;

  // One flag cell per source. The event pulse sets the flag, and a set
  // beats a clear written for the same bit in the same cycle.
  for (genvar g = 0; g < NUM_EVT; g++) begin : gFlag
    assign flagNext[g] = evtPulse[g] | (flagQ[g] & ~clrMask[g]);
    always_ff @(posedge clk) begin
      if (!rstN) flagQ[g] <= 1'b0;
      else       flagQ[g] <= flagNext[g];
    end
  end

  assign enNext = st.enWr ? wrData[NUM_EVT-1:0] : enQ;

  always_ff @(posedge clk) begin
    if (!rstN) enQ <= '0;
    else       enQ <= enNext;
  end

  // The output register is fed from the next-state values, so an enable
  // write or an event takes effect on irqOut at the same edge as on the
  // registers.
  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(flagNext & enNext);
  end

  always_comb begin
    if (st.rdFlag)    rdData = {{PAD_W{1'b0}}, flagQ};
    else if (st.rdEn) rdData = {{PAD_W{1'b0}}, enQ};
    else              rdData = '0;
  end
endmodule

// File: rtl/evtirq_top.sv
module evtirq_top
  import evtirq_pkg::*;
#(
  parameter int NUM_EVT   = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 0,
  parameter int EN_ADDR   = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic               irqOut
);
  strobe_t            st;
  logic [NUM_EVT-1:0] flagQ;
  logic [NUM_EVT-1:0] enQ;

  evtirq_ctrl #(
    .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
  ) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .st(st)
  );

  evtirq_datapath #(
    .NUM_EVT(NUM_EVT), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(regWrData),
    .evtPulse(evtPulse), .rdData(regRdData), .flagQ(flagQ),
    .enQ(enQ), .irqOut(irqOut)
  );
endmodule

// File: rtl/evtirq_chk.sv
module evtirq_chk #(
  parameter int NUM_EVT   = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 0,
  parameter int EN_ADDR   = 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [DATA_W-1:0]  regWrData,
  input logic [DATA_W-1:0]  regRdData,
  input logic [NUM_EVT-1:0] evtPulse,
  input logic               irqOut,
  input logic [NUM_EVT-1:0] flagQ,
  input logic [NUM_EVT-1:0] enQ
);
  logic wrFlag, wrEn, wrOther;
  assign wrFlag  = regWrEn && (regAddr == ADDR_W'(FLAG_ADDR));
  assign wrEn    = regWrEn && (regAddr == ADDR_W'(EN_ADDR));
  assign wrOther = regWrEn && !wrFlag && !wrEn;

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((flagQ & $past(evtPulse)) == $past(evtPulse)));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:NUM_EVT] == '0);

  assert_clear_ones_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrFlag |=> ((flagQ & $past(regWrData[NUM_EVT-1:0]) & ~$past(evtPulse)) == '0));

  assert_enable_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (enQ == $past(regWrData[NUM_EVT-1:0])));

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((flagQ & enQ) != '0));

  assert_mask_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regWrData[NUM_EVT-1:0] == '0) |=> !irqOut);

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrOther |=> $stable(enQ));
endmodule

bind evtirq_top evtirq_chk #(
  .NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse),
  .irqOut(irqOut), .flagQ(flagQ), .enQ(enQ)
);

// File: tb/sim_evtirq_top.sv
module sim_evtirq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  evtPulse = '0;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] mFlag = '0;
  logic [7:0] mEn   = '0;

  always #2 clk = ~clk;

  evtirq_top u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse),
    .irqOut(irqOut)
  );

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    if (a == 4'd0)      return {24'd0, mFlag};
    else if (a == 4'd1) return {24'd0, mEn};
    else                return 32'd0;
  endfunction

  function automatic logic [7:0] nextFlag(input logic [3:0] a, input logic we,
                                          input logic [31:0] d, input logic [7:0] e);
    logic [7:0] clr;
    clr = (we && a == 4'd0) ? d[7:0] : 8'd0;
    return e | (mFlag & ~clr);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge. Drives one cycle, checks the read data
  // combinationally, then checks irqOut at the next falling edge.
  task automatic cyc(input logic [3:0] a, input logic we, input logic [31:0] d,
                     input logic [7:0] e, input string tag);
    logic [7:0] nf;
    regAddr = a; regWrEn = we; regWrData = d; evtPulse = e;
    #1;
    check(regRdData, modelRead(a), tag);
    @(posedge clk);
    nf = nextFlag(a, we, d, e);
    if (we && a == 4'd1) mEn = d[7:0];
    mFlag = nf;
    @(negedge clk);
    check({31'd0, irqOut}, {31'd0, |(mFlag & mEn)}, tag);
  endtask

  task automatic idle(input logic [3:0] a, input string tag);
    cyc(a, 1'b0, 32'd0, 8'd0, tag);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: reset state, checked while reset is held and after release.
    repeat (3) @(negedge clk);
    #1;
    check({31'd0, irqOut}, 32'd0, "R1");
    regAddr = 4'd0; #1; check(regRdData, 32'd0, "R1");
    regAddr = 4'd1; #1; check(regRdData, 32'd0, "R1");
    @(negedge clk);
    rstN = 1'b1;
    idle(4'd0, "R1");
    idle(4'd1, "R1");

    // R2: every source sets its flag with enables off, no interrupt.
    for (int i = 0; i < 8; i++) cyc(4'd2, 1'b0, 32'd0, 8'(1 << i), "R2");
    idle(4'd0, "R2");

    // R4: clear a subset with junk in the upper write-data bits.
    cyc(4'd0, 1'b1, 32'hFFFF_FF5A, 8'd0, "R4");
    idle(4'd0, "R4");
    cyc(4'd0, 1'b1, 32'h0000_00A5, 8'd0, "R4");
    idle(4'd0, "R4");

    // R5: set and clear of the same bit in the same cycle.
    cyc(4'd0, 1'b0, 32'd0, 8'h18, "R5");
    cyc(4'd0, 1'b1, 32'h0000_00FF, 8'h10, "R5");
    idle(4'd0, "R5");

    // R6 / R7: enabling a pending flag raises the interrupt.
    cyc(4'd1, 1'b1, 32'hABCD_0010, 8'd0, "R6");
    idle(4'd1, "R6");
    cyc(4'd0, 1'b1, 32'h0000_0010, 8'd0, "R7");
    idle(4'd0, "R7");

    // R8: disabling drops the interrupt at once, even with a new event.
    cyc(4'd1, 1'b1, 32'h0000_00FF, 8'h03, "R8");
    cyc(4'd1, 1'b1, 32'h0000_0000, 8'h04, "R8");
    idle(4'd0, "R8");

    // R9: bus error recorded but masked, then unmasked.
    cyc(4'd0, 1'b1, 32'h0000_00FF, 8'd0, "R9");
    cyc(4'd1, 1'b1, 32'h0000_007F, 8'd0, "R9");
    cyc(4'd0, 1'b0, 32'd0, 8'h80, "R9");
    idle(4'd0, "R9");
    cyc(4'd1, 1'b1, 32'h0000_00FF, 8'd0, "R9");
    idle(4'd1, "R9");

    // R10 / R3: unmapped writes have no effect and unmapped reads are zero.
    cyc(4'd2, 1'b1, 32'h0000_0000, 8'd0, "R10");
    cyc(4'd15, 1'b1, 32'h0000_00FF, 8'd0, "R10");
    idle(4'd0, "R10");
    idle(4'd1, "R10");
    idle(4'd7, "R3");

    // Random traffic with sparse events.
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  a;
      logic        we;
      logic [31:0] d;
      logic [7:0]  e;
      a  = ($urandom % 8 < 6) ? 4'($urandom % 2) : 4'($urandom);
      we = ($urandom % 3) == 0;
      d  = $urandom;
      e  = 8'($urandom & $urandom & $urandom);
      cyc(a, we, d, e, "R7");
    end

    regWrEn = 1'b0; evtPulse = '0;
    finishRun();
  end
endmodule